// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block sits between an internal request port and an external asynchronous static RAM of 64K words by 16 bits. The RAM has active-low select, output-enable and write-enable strobes, plus one active-low enable per byte lane. The host presents an address, a write flag, a per-lane mask and write data. The controller then runs the RAM strobes through a fixed sequence. The minimum access, pulse and setup times are given in nanoseconds, and the controller turns each one into whole cycles of its own clock.

Reads follow this order: select and lane enables go low, then output enable goes low, the controller waits for the access time, and the result is captured in a register. Writes follow this order: the controller drives the data bus, pulses write enable while select and the lane enables are already low, and keeps data and address held while write enable rises. Output enable stays high for the whole write, so only the short write-pulse minimum applies. The data pins are split at the controller's edge into an outgoing value, a drive enable and an incoming value. When a request's mask is zero, it finishes at once and no strobe moves.

Top module: `sram_byte_ctl`

## Requirements
- R1: While reset is asserted, all strobes (select, output enable, write enable, both lane enables) are high, the data drive is off, `done` is low and `req_ready` is high.
- R2: A write changes only the lanes whose mask bit is set. Mask bit 1 and `mem_be_n[1]` select bits 15..8. Mask bit 0 and `mem_be_n[0]` select bits 7..0. Unselected lanes of the stored word keep their old value.
- R3: Write enable is low only while select is low and at least one lane enable is low. Each low period lasts at least ceil(tWP/tclk) and at least ceil(tDW/tclk) cycles, with a floor of one cycle. `mem_dq_out` is driven and held stable throughout that period.
- R4: Output enable is high in every cycle where the data drive is on or write enable is low. The data drive is off in the cycle before output enable falls.
- R5: A read holds write enable high. Read data is sampled only after select has been low for at least ceil(tAA/tclk) cycles and output enable has been low for at least ceil(tOE/tclk) cycles.
- R6: A read returns zero in every lane of `rd_data` whose mask bit is clear, whatever the bus carries on that lane.
- R7: A request with mask 00 raises `done` in the cycle after it is accepted. No strobe falls and the data drive never turns on. The stored data is unchanged.
- R8: `mem_addr` holds steady for as long as select stays low.
- R9: `req_ready` is high only while idle. `done` is a one-cycle pulse, raised once per accepted request, and every strobe is high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_mask | input | 2 | Lane mask, bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Controller idle; a valid request is taken at the next edge |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data, masked lanes zero |
| mem_addr | output | 16 | RAM address |
| mem_cs_n | output | 1 | RAM select, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_be_n | output | 2 | RAM lane enables, active low, bit 1 upper |
| mem_dq_out | output | 16 | Data toward the RAM pins |
| mem_dq_drive | output | 1 | Pad drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data from the RAM pins |

## Verification
The bench mixes directed cases with seeded random traffic. The directed cases are full-word, single-lane and empty-mask writes and reads at the lowest and highest addresses. The random traffic uses a small address pool so that partial writes pile up on the same word.

Single-lane writes followed by full-word reads show whether the lane merge keeps the untouched byte. Single-lane reads show whether junk on a disabled lane leaks into the result. The RAM model returns a marker value if select or output enable has not been low for the minimum access time, which separates a correct wait from a shortened one. The empty-mask requests are checked for one-cycle completion with no strobe activity.

// File: rtl/sram_byte_ctl_pkg.sv
`timescale 1ns/1ps
// Shared types and compile-time helpers for the byte-lane SRAM controller.
// Assumes all timing values are non-negative integers in nanoseconds.
package sram_byte_ctl_pkg;

    // Sequencer states; read and write paths are disjoint after IDLE.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ASSERT,
        ST_RD_WAIT,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RELEASE
    } seq_state_t;

    // Round a nanosecond time up to whole clock cycles; zero stays zero.
    function automatic int ns_to_cycles(input int t_ns, input int period_ns);
        if (t_ns <= 0) return 0;
        return (t_ns + period_ns - 1) / period_ns;
    endfunction

    // Larger of two integers.
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
// Down-counter that sets how long the sequencer stays in a timed state.
// Loaded with (length - 1) when a state is entered; zero marks the last cycle.
// Assumes a load value never exceeds 2**TW - 1.
module sram_ctl_timer #(
    parameter int TW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    // Load on state entry, otherwise count down and stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_seq.sv
`timescale 1ns/1ps
// Access sequencer: walks the read or write state path and produces
// registered RAM strobes, the data-drive enable and the completion pulse.
// Assumes every *_LEN parameter is at least 1 and fits in TW bits once reduced by one.
module sram_ctl_seq
    import sram_byte_ctl_pkg::*;
#(
    parameter int LANES     = 2,
    parameter int TW        = 2,
    parameter int SETUP_LEN = 1,
    parameter int PULSE_LEN = 1,
    parameter int REL_LEN   = 1,
    parameter int WAIT_LEN  = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [LANES-1:0] req_mask,
    input  logic             tmr_zero,
    output logic             accept,
    output logic             capture,
    output logic             ready,
    output logic             done,
    output logic             cs_n,
    output logic             oe_n,
    output logic             we_n,
    output logic [LANES-1:0] be_n,
    output logic             drive,
    output logic             tmr_load,
    output logic [TW-1:0]    tmr_val
);

    localparam logic [TW-1:0] SETUP_LOAD = TW'(SETUP_LEN - 1);
    localparam logic [TW-1:0] PULSE_LOAD = TW'(PULSE_LEN - 1);
    localparam logic [TW-1:0] REL_LOAD   = TW'(REL_LEN - 1);
    localparam logic [TW-1:0] WAIT_LOAD  = TW'(WAIT_LEN - 1);

    seq_state_t       state_q, state_d;
    logic             cs_q, oe_q, we_q, drv_q, done_q;
    logic             cs_d, oe_d, we_d, drv_d, done_d;
    logic [LANES-1:0] be_q, be_d;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign ready  = (state_q == ST_IDLE);

    // Next-state and next-strobe decode for both access paths.
    always_comb begin
        state_d  = state_q;
        cs_d     = cs_q;
        oe_d     = oe_q;
        we_d     = we_q;
        be_d     = be_q;
        drv_d    = drv_q;
        done_d   = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (req_mask == '0) begin
                        done_d = 1'b1;
                    end else if (req_write) begin
                        state_d  = ST_WR_SETUP;
                        cs_d     = 1'b0;
                        be_d     = ~req_mask;
                        drv_d    = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = SETUP_LOAD;
                    end else begin
                        state_d = ST_RD_ASSERT;
                        cs_d    = 1'b0;
                        be_d    = ~req_mask;
                    end
                end
            end
            ST_RD_ASSERT: begin
                state_d  = ST_RD_WAIT;
                oe_d     = 1'b0;
                tmr_load = 1'b1;
                tmr_val  = WAIT_LOAD;
            end
            ST_RD_WAIT: begin
                if (tmr_zero) state_d = ST_RD_CAPTURE;
            end
            ST_RD_CAPTURE: begin
                capture = 1'b1;
                state_d = ST_IDLE;
                cs_d    = 1'b1;
                oe_d    = 1'b1;
                be_d    = '1;
                done_d  = 1'b1;
            end
            ST_WR_SETUP: begin
                if (tmr_zero) begin
                    state_d  = ST_WR_PULSE;
                    we_d     = 1'b0;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LOAD;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_zero) begin
                    state_d  = ST_WR_RELEASE;
                    we_d     = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = REL_LOAD;
                end
            end
            ST_WR_RELEASE: begin
                if (tmr_zero) begin
                    state_d = ST_IDLE;
                    cs_d    = 1'b1;
                    be_d    = '1;
                    drv_d   = 1'b0;
                    done_d  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and strobe registers; reset parks every strobe high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cs_q    <= 1'b1;
            oe_q    <= 1'b1;
            we_q    <= 1'b1;
            be_q    <= '1;
            drv_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cs_q    <= cs_d;
            oe_q    <= oe_d;
            we_q    <= we_d;
            be_q    <= be_d;
            drv_q   <= drv_d;
            done_q  <= done_d;
        end
    end

    assign cs_n  = cs_q;
    assign oe_n  = oe_q;
    assign we_n  = we_q;
    assign be_n  = be_q;
    assign drive = drv_q;
    assign done  = done_q;

endmodule

// File: rtl/sram_ctl_dpath.sv
`timescale 1ns/1ps
// Datapath: holds address, write data and lane mask for the access in flight,
// and captures read data lane by lane, clearing lanes the mask left out.
// Assumes DATA_W is a whole multiple of LANE_W.
module sram_ctl_dpath #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LANES-1:0]  req_mask,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_data
);

    logic [LANES-1:0] mask_q;

    // Latch the request fields when the sequencer takes a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr <= '0;
            dq_out   <= '0;
            mask_q   <= '0;
        end else if (accept) begin
            mem_addr <= req_addr;
            dq_out   <= req_wdata;
            mask_q   <= req_mask;
        end
    end

    // One capture register per lane; a lane outside the mask reads as zero.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_data[g*LANE_W +: LANE_W] <= '0;
            end else if (capture) begin
                rd_data[g*LANE_W +: LANE_W] <= mask_q[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end
    end

endmodule

// File: rtl/sram_byte_ctl.sv
`timescale 1ns/1ps
// Top of the byte-lane asynchronous SRAM controller. Converts the RAM's
// nanosecond timing limits to cycle counts, then ties the sequencer, the
// state timer and the datapath together. The data pins are split into
// out / drive-enable / in so that the pad ring owns the tristate.
module sram_byte_ctl
    import sram_byte_ctl_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 16,
    parameter int LANE_W  = 8,
    parameter int CLK_NS  = 8,
    parameter int T_RC_NS = 12,
    parameter int T_AA_NS = 12,
    parameter int T_OE_NS = 6,
    parameter int T_WC_NS = 12,
    parameter int T_WP_NS = 8,
    parameter int T_DW_NS = 6,
    parameter int T_AS_NS = 0,
    parameter int T_WR_NS = 0,
    parameter int T_DH_NS = 0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [DATA_W/LANE_W-1:0]     req_mask,
    input  logic [DATA_W-1:0]            req_wdata,
    output logic                         req_ready,
    output logic                         done,
    output logic [DATA_W-1:0]            rd_data,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic                         mem_cs_n,
    output logic                         mem_oe_n,
    output logic                         mem_we_n,
    output logic [DATA_W/LANE_W-1:0]     mem_be_n,
    output logic [DATA_W-1:0]            mem_dq_out,
    output logic                         mem_dq_drive,
    input  logic [DATA_W-1:0]            mem_dq_in
);

    localparam int LANES = DATA_W / LANE_W;

    localparam int C_RC = ns_to_cycles(T_RC_NS, CLK_NS);
    localparam int C_AA = ns_to_cycles(T_AA_NS, CLK_NS);
    localparam int C_OE = ns_to_cycles(T_OE_NS, CLK_NS);
    localparam int C_WC = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int C_WP = ns_to_cycles(T_WP_NS, CLK_NS);
    localparam int C_DW = ns_to_cycles(T_DW_NS, CLK_NS);
    localparam int C_AS = ns_to_cycles(T_AS_NS, CLK_NS);
    localparam int C_WR = ns_to_cycles(T_WR_NS, CLK_NS);
    localparam int C_DH = ns_to_cycles(T_DH_NS, CLK_NS);

    // Write phases: setup with data driven, pulse, release with data held.
    localparam int SETUP_LEN = imax(C_AS, 1);
    localparam int PULSE_LEN = imax(imax(C_WP, C_DW), 1);
    localparam int REL_LEN   = imax(imax(imax(C_WR, C_DH), 1), C_WC - SETUP_LEN - PULSE_LEN);
    // Read wait: the assert cycle already counts toward address access.
    localparam int WAIT_LEN  = imax(imax(imax(C_AA - 1, C_OE), 1), C_RC - 2);

    localparam int LEN_MAX = imax(imax(SETUP_LEN, PULSE_LEN), imax(REL_LEN, WAIT_LEN));
    localparam int TW      = imax($clog2(LEN_MAX + 1), 1);

    logic          accept;
    logic          capture;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_zero;

    sram_ctl_seq #(
        .LANES    (LANES),
        .TW       (TW),
        .SETUP_LEN(SETUP_LEN),
        .PULSE_LEN(PULSE_LEN),
        .REL_LEN  (REL_LEN),
        .WAIT_LEN (WAIT_LEN)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_mask (req_mask),
        .tmr_zero (tmr_zero),
        .accept   (accept),
        .capture  (capture),
        .ready    (req_ready),
        .done     (done),
        .cs_n     (mem_cs_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .be_n     (mem_be_n),
        .drive    (mem_dq_drive),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val)
    );

    sram_ctl_timer #(
        .TW(TW)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    sram_ctl_dpath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .LANE_W(LANE_W),
        .LANES (LANES)
    ) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .capture  (capture),
        .req_addr (req_addr),
        .req_mask (req_mask),
        .req_wdata(req_wdata),
        .dq_in    (mem_dq_in),
        .mem_addr (mem_addr),
        .dq_out   (mem_dq_out),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/sram_byte_ctl_chk.sv
`timescale 1ns/1ps
// Protocol checker for the SRAM controller, observing its ports only.
// Attached to every instance of the top by the bind below.
module sram_byte_ctl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANES  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [LANES-1:0]  req_mask,
    input logic              req_ready,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [LANES-1:0]  mem_be_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_drive
);

    // R3
    we_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_cs_n && (mem_be_n != '1)));

    // R3
    wdata_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && $past(!mem_we_n)) |-> ($stable(mem_dq_out) && mem_dq_drive));

    // R4
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (!mem_dq_drive && mem_we_n));

    // R4
    release_before_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_oe_n) |-> !$past(mem_dq_drive));

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    // R9
    done_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && mem_cs_n && mem_oe_n && mem_we_n && (mem_be_n == '1)));

    // R7
    empty_mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && (req_mask == '0)) |=> (mem_cs_n && !mem_dq_drive && done));

endmodule

bind sram_byte_ctl sram_byte_ctl_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (DATA_W / LANE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_mask    (req_mask),
    .req_ready   (req_ready),
    .done        (done),
    .mem_addr    (mem_addr),
    .mem_cs_n    (mem_cs_n),
    .mem_oe_n    (mem_oe_n),
    .mem_we_n    (mem_we_n),
    .mem_be_n    (mem_be_n),
    .mem_dq_out  (mem_dq_out),
    .mem_dq_drive(mem_dq_drive)
);

// File: tb/sram_byte_ctl_tb.sv
`timescale 1ns/1ps
// Bench: behavioural RAM model sampled at falling edges, a reference array
// for expected data, and directed plus seeded random requests.
module sram_byte_ctl_tb;

    localparam int CLK_NS = 8;
    localparam int T_AA = 12, T_OE = 6, T_WP = 8, T_DW = 6;

    function automatic int cyc(input int t);
        return (t <= 0) ? 0 : (t + CLK_NS - 1) / CLK_NS;
    endfunction

    localparam int MIN_AA = cyc(T_AA);
    localparam int MIN_OE = cyc(T_OE);
    localparam int MIN_WE = (cyc(T_WP) > cyc(T_DW)) ? cyc(T_WP) : cyc(T_DW);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        req_ready, done;
    logic [15:0] rd_data, mem_addr, mem_dq_out;
    logic [15:0] mem_dq_in = '0;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_drive;
    logic [1:0]  mem_be_n;

    always #4 clk = ~clk;

    sram_byte_ctl #(
        .CLK_NS(CLK_NS), .T_RC_NS(12), .T_AA_NS(T_AA), .T_OE_NS(T_OE),
        .T_WC_NS(12), .T_WP_NS(T_WP), .T_DW_NS(T_DW),
        .T_AS_NS(0), .T_WR_NS(0), .T_DH_NS(0)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_dq_out(mem_dq_out),
        .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
    );

    int nvec = 0, nfail = 0;
    bit finished = 1'b0;
    int activity = 0;
    logic [15:0] ref_mem[int];
    logic [15:0] ram[int];

    function automatic logic [15:0] gate(input logic [15:0] v, input logic [1:0] m);
        return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
    endfunction

    function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] n, input logic [1:0] m);
        return {m[1] ? n[15:8] : o[15:8], m[0] ? n[7:0] : o[7:0]};
    endfunction

    function automatic logic [15:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] ram_rd(input int a);
        return ram.exists(a) ? ram[a] : 16'h0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic mon_fail(input string req, input logic [31:0] act, input logic [31:0] exp);
        nfail++;
        $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    endtask

    // RAM model and protocol monitor, evaluated at falling edges.
    int cs_len = 0, oe_len = 0, we_len = 0;
    logic [15:0] w_data, w_addr, prev_addr = '0;
    logic [1:0]  w_be;
    logic        prev_cs_low = 1'b0, prev_oe_n = 1'b1, prev_drive = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_cs_n || !mem_oe_n || !mem_we_n || mem_dq_drive || mem_be_n != 2'b11)
                activity++;
            cs_len = !mem_cs_n ? cs_len + 1 : 0;
            oe_len = !mem_oe_n ? oe_len + 1 : 0;
            // R8 address held while selected
            if (!mem_cs_n && prev_cs_low && mem_addr !== prev_addr)
                mon_fail("R8 addr moved", mem_addr, prev_addr);
            // R4 no contention, turnaround before output enable
            if (!mem_oe_n && (mem_dq_drive || !mem_we_n))
                mon_fail("R4 oe low with drive or we", {mem_dq_drive, mem_we_n}, 2'b01);
            if (!mem_oe_n && prev_oe_n && prev_drive)
                mon_fail("R4 drive not released before oe", prev_drive, 1'b0);
            // R3 write pulse
            if (!mem_we_n) begin
                if (mem_cs_n || mem_be_n == 2'b11)
                    mon_fail("R3 we without select", {mem_cs_n, mem_be_n}, 3'b000);
                if (!mem_dq_drive)
                    mon_fail("R3 data not driven in pulse", mem_dq_drive, 1'b1);
                if (we_len > 0 && mem_dq_out !== w_data)
                    mon_fail("R3 data moved in pulse", mem_dq_out, w_data);
                we_len++;
                w_data = mem_dq_out;
                w_addr = mem_addr;
                w_be   = mem_be_n;
            end else if (we_len > 0) begin
                nvec++;
                if (we_len < MIN_WE)
                    mon_fail("R3 pulse too short", we_len, MIN_WE);
                ram[int'(w_addr)] = merge(ram_rd(int'(w_addr)), w_data, ~w_be);
                we_len = 0;
            end
            // R5 read returns data only once access times are met
            if (!mem_cs_n && !mem_oe_n && mem_we_n) begin
                if (cs_len >= MIN_AA && oe_len >= MIN_OE)
                    mem_dq_in <= {mem_be_n[1] ? 8'hA5 : ram_rd(int'(mem_addr))[15:8],
                                  mem_be_n[0] ? 8'h5A : ram_rd(int'(mem_addr))[7:0]};
                else
                    mem_dq_in <= 16'hDEAD;
            end else begin
                mem_dq_in <= 16'hC3C3;
            end
            prev_cs_low = !mem_cs_n;
            prev_addr   = mem_addr;
            prev_oe_n   = mem_oe_n;
            prev_drive  = mem_dq_drive;
        end
    end

    // One request from presentation to completion; returns latency and read data.
    task automatic do_req(input bit wr, input logic [15:0] a, input logic [1:0] m,
                          input logic [15:0] d, output logic [15:0] rd, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_mask = m; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done && lat < 50) begin
            // R9 not ready while busy
            if (req_ready) mon_fail("R9 ready while busy", req_ready, 1'b0);
            @(negedge clk);
            lat++;
        end
        if (!done) mon_fail("R9 no done", 0, 1);
        rd = rd_data;
        @(negedge clk);
        // R9 done is a single pulse
        chk("R9 done pulse width", done, 1'b0);
    endtask

    task automatic wr_op(input logic [15:0] a, input logic [1:0] m, input logic [15:0] d);
        logic [15:0] rd;
        int lat, act0;
        act0 = activity;
        do_req(1'b1, a, m, d, rd, lat);
        ref_mem[int'(a)] = merge(ref_rd(int'(a)), d, m);
        if (m == 2'b00) begin
            chk("R7 empty write latency", lat, 1);
            chk("R7 empty write strobes", activity - act0, 0);
        end
    endtask

    task automatic rd_op(input logic [15:0] a, input logic [1:0] m, input string tag);
        logic [15:0] rd;
        int lat, act0;
        act0 = activity;
        do_req(1'b0, a, m, 16'h0, rd, lat);
        if (m == 2'b00) begin
            chk("R7 empty read latency", lat, 1);
            chk("R7 empty read strobes", activity - act0, 0);
        end else begin
            chk(tag, rd, gate(ref_rd(int'(a)), m));
        end
    endtask

    initial begin
        logic [15:0] a;
        int unsigned seed;
        seed = $urandom(32'h5EED_0123);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1 strobes in reset", {mem_cs_n, mem_oe_n, mem_we_n, mem_be_n}, 5'b11111);
        chk("R1 drive/done/ready in reset", {mem_dq_drive, done, req_ready}, 3'b001);
        rst_n = 1'b1;

        // Directed corners
        wr_op(16'h0000, 2'b11, 16'h1234);
        wr_op(16'hFFFF, 2'b11, 16'hBEEF);
        rd_op(16'h0000, 2'b11, "R5 full read low corner");
        rd_op(16'hFFFF, 2'b11, "R5 full read high corner");
        wr_op(16'h0000, 2'b01, 16'hAACD);   // R2 lower lane only
        rd_op(16'h0000, 2'b11, "R2 lower-lane merge");
        wr_op(16'hFFFF, 2'b10, 16'h77AA);   // R2 upper lane only
        rd_op(16'hFFFF, 2'b11, "R2 upper-lane merge");
        rd_op(16'hFFFF, 2'b10, "R6 upper-only read");
        rd_op(16'h0000, 2'b01, "R6 lower-only read");
        wr_op(16'h0000, 2'b00, 16'h9999);   // R7 must not change data
        rd_op(16'h0000, 2'b11, "R7 data unchanged");
        rd_op(16'h0000, 2'b00, "R7 empty read");

        // Seeded random traffic on a small address pool plus stray addresses
        for (int i = 0; i < 300; i++) begin
            a = ($urandom % 5 == 0) ? 16'($urandom) : 16'($urandom % 8);
            if ($urandom % 2 == 0)
                wr_op(a, 2'($urandom), 16'($urandom));
            else
                rd_op(a, 2'($urandom), "R5/R6 random read");
        end

        // R2 final sweep: RAM contents against the reference
        foreach (ref_mem[k]) chk("R2 stored word", ram_rd(k), ref_mem[k]);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nfail++;
            $display("FAIL R9 watchdog actual=hung expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

endmodule